// File: doc/BRIEF.md
# Windowed watchdog timer with early warning

This block watches system software through a 7-bit downcounter that software must reload neither too late nor too early. Once armed, the counter decrements on every tick of a two-stage prescaler: a fixed divider of the peripheral clock enable, followed by a selectable divider of 1, 2, 4 or 8. If the counter's bit 6 drops (the step from 0x40 to 0x3F) the block requests a system reset. A reload written while the counter still sits above a programmable window value is treated as a misbehaving refresh and also requests a reset.

One tick before the fatal step, when the counter lands on 0x40, a status flag is raised. With the early-warning enable set, the flag drives an interrupt line. This gives software a last chance to reload. The register interface has a write strobe and combinational read data. It uses three word offsets: control at 0x00, configuration at 0x04 and status at 0x08.

Top module: `win_watchdog`

## Requirements
- R1: After reset, control reads 0x0000007F (counter 0x7F, inactive), configuration reads 0x0000007F (window 0x7F, time base 00, warning disabled), status reads 0, and both outputs are low.
- R2: While inactive, the counter holds. While active, it decrements by one every PRE_DIV × 2^tb asserted peripheral clock enables. The first decrement comes PRE_DIV × 2^tb enables after the activating write.
- R3: The time base field (configuration bits 8:7) selects a second divider of 1, 2 or 4 or 8 for codes 00, 01, 10 or 11.
- R4: The activation bit (control bit 7) is set by writing 1. Writing 0 to it leaves it set.
- R5: While active, the step of the counter from 0x40 to 0x3F gives a one-cycle pulse on rst_req. The pulse appears in the same cycle the counter reads 0x3F.
- R6: A control write while active and the counter is greater than the window value (configuration bits 6:0) gives a rst_req pulse in the next cycle. The counter is not loaded.
- R7: A control write while inactive, or while the counter is at or below the window value, loads control bits 6:0 into the counter. If bit 6 is set, no reset is requested.
- R8: An accepted control write that leaves the block active with counter bit 6 clear gives a rst_req pulse in the next cycle.
- R9: The status flag (status bit 0) is set when the counter decrements to 0x40, whether or not the warning is enabled.
- R10: Writing 0 to status bit 0 clears the flag. Writing 1 leaves it unchanged.
- R11: The early-warning enable (configuration bit 9) is set by writing 1 and is not cleared by writing 0.
- R12: early_irq is high exactly while the flag and the enable are both set.
- R13: Reserved bits read 0 and ignore writes. Control uses bits 7:0, configuration bits 9:0 and status bit 0. Unmapped offsets read 0.
- R14: While pclk_en is low, the prescaler and the counter do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk_en | input | 1 | Peripheral clock enable feeding the prescaler |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rdata | output | 32 | Read data for addr, combinational |
| rst_req | output | 1 | One-cycle system reset request |
| early_irq | output | 1 | Early-warning interrupt, level |

## Verification
A wrong prescaler phase or a wrong time-base decode shows up as a counter readback that is off by one step, no later than the first decrement. The bench sweeps every cycle of the first few periods for all four time-base codes. A corrupted counter or window comparison shows at rst_req within one cycle of the deciding write or the 0x40 step, because the pulse is registered from that edge. A flag or enable error is visible on early_irq and the status readback in the cycle after the event that should have changed it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int CNT_W    = 7;
    localparam int TB_W     = 2;

    localparam int OFF_CTRL = 'h0;
    localparam int OFF_CFG  = 'h4;
    localparam int OFF_STAT = 'h8;

    localparam logic [CNT_W-1:0] CNT_RST  = 7'h7F;
    localparam logic [CNT_W-1:0] WARN_VAL = 7'h40;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             rst;
    } cnt_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] win;
        logic [TB_W-1:0]  tb;
        logic             ewi;
        logic             flag;
    } cfg_state_t;

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int PRE_DIV = 4096,
    parameter int TB_W    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            pclk_en,
    input  logic [TB_W-1:0] tb,
    output logic            tick
);
    localparam int P_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
    localparam int S_W = (1 << TB_W) - 1;

    typedef struct packed {
        logic [P_W-1:0] pre;
        logic [S_W-1:0] post;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       base_tick;
    logic [S_W-1:0] limit;

    always_comb begin
        st_d      = st_q;
        base_tick = 1'b0;
        tick      = 1'b0;
        limit     = S_W'((1 << tb) - 1);
        if (!run) begin
            st_d = '0;
        end else if (pclk_en) begin
            if (st_q.pre == P_W'(PRE_DIV - 1)) begin
                st_d.pre  = '0;
                base_tick = 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
            if (base_tick) begin
                if (st_q.post >= limit) begin
                    st_d.post = '0;
                    tick      = 1'b1;
                end else begin
                    st_d.post = st_q.post + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic [CNT_W:0]   ctrl_wdata,
    input  logic [CNT_W-1:0] win,
    output logic [CNT_W-1:0] cnt,
    output logic             active,
    output logic             hit_warn,
    output logic             rst_req
);
    cnt_state_t st_d, st_q;
    logic       accept, reject, fire, arm_next;

    always_comb begin
        st_d     = st_q;
        fire     = 1'b0;
        hit_warn = 1'b0;
        reject   = ctrl_wr && st_q.active && (st_q.cnt > win);
        accept   = ctrl_wr && !reject;
        arm_next = st_q.active | ctrl_wdata[CNT_W];
        if (reject) begin
            fire = 1'b1;
        end
        if (accept) begin
            st_d.cnt    = ctrl_wdata[CNT_W-1:0];
            st_d.active = arm_next;
            if (arm_next && !ctrl_wdata[CNT_W-1]) fire = 1'b1;
        end else if (st_q.active && tick) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == WARN_VAL)          fire     = 1'b1;
            if (st_q.cnt == WARN_VAL + 7'd1)   hit_warn = 1'b1;
        end
        st_d.rst = fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: CNT_RST, active: 1'b0, rst: 1'b0};
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign active  = st_q.active;
    assign rst_req = st_q.rst;

    a_r4_active_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> active);
    a_r2_hold_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !ctrl_wr) |=> $stable(cnt));
    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && !ctrl_wr) |=> (cnt == $past(cnt) - 7'd1));
    a_r5_reset_on_bit6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && !ctrl_wr && cnt == WARN_VAL) |=> (rst_req && cnt == 7'h3F));
    a_r6_early_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && active && cnt > win) |=> rst_req);

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             stat_wr,
    input  logic [9:0]       wdata,
    input  logic             hit_warn,
    output logic [CNT_W-1:0] win,
    output logic [TB_W-1:0]  tb,
    output logic             ewi,
    output logic             flag,
    output logic             irq
);
    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.win = wdata[CNT_W-1:0];
            st_d.tb  = wdata[CNT_W+TB_W-1:CNT_W];
            st_d.ewi = st_q.ewi | wdata[CNT_W+TB_W];
        end
        if (stat_wr && !wdata[0]) st_d.flag = 1'b0;
        if (hit_warn)             st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{win: CNT_RST, tb: '0, ewi: 1'b0, flag: 1'b0};
        else        st_q <= st_d;
    end

    assign win  = st_q.win;
    assign tb   = st_q.tb;
    assign ewi  = st_q.ewi;
    assign flag = st_q.flag;
    assign irq  = st_q.flag & st_q.ewi;

    a_r11_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ewi |=> ewi);
    a_r9_flag_on_warn: assert property (@(posedge clk) disable iff (!rst_n)
        hit_warn |=> flag);
    a_r10_flag_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(stat_wr && !wdata[0]));

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wdg_pkg::*;
#(
    parameter int PRE_DIV = 4096,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wr_en,
    output logic [31:0]       rdata,
    output logic              rst_req,
    output logic              early_irq
);
    logic             sel_ctrl, sel_cfg, sel_stat;
    logic             tick, active, hit_warn, ewi, flag;
    logic [CNT_W-1:0] cnt, win;
    logic [TB_W-1:0]  tb;
    logic             unused_hi;

    assign sel_ctrl  = (addr == ADDR_W'(OFF_CTRL));
    assign sel_cfg   = (addr == ADDR_W'(OFF_CFG));
    assign sel_stat  = (addr == ADDR_W'(OFF_STAT));
    assign unused_hi = ^wdata[31:10];

    wdg_prescaler #(.PRE_DIV(PRE_DIV), .TB_W(TB_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (active),
        .pclk_en (pclk_en),
        .tb      (tb),
        .tick    (tick)
    );

    wdg_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .ctrl_wr    (wr_en && sel_ctrl),
        .ctrl_wdata (wdata[CNT_W:0]),
        .win        (win),
        .cnt        (cnt),
        .active     (active),
        .hit_warn   (hit_warn),
        .rst_req    (rst_req)
    );

    wdg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (wr_en && sel_cfg),
        .stat_wr  (wr_en && sel_stat),
        .wdata    (wdata[9:0]),
        .hit_warn (hit_warn),
        .win      (win),
        .tb       (tb),
        .ewi      (ewi),
        .flag     (flag),
        .irq      (early_irq)
    );

    always_comb begin
        rdata = '0;
        if (sel_ctrl)      rdata[CNT_W:0]        = {active, cnt};
        else if (sel_cfg)  rdata[CNT_W+TB_W:0]   = {ewi, tb, win};
        else if (sel_stat) rdata[0]              = flag;
    end

    a_r14_stall_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!pclk_en && !(wr_en && sel_ctrl)) |=> $stable(cnt));

endmodule

// File: tb/win_watchdog_test.sv
`timescale 1ns/1ps
module win_watchdog_test;
    localparam int PRE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pclk_en = 1'b1;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic [31:0] rdata;
    logic        rst_req, early_irq;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    win_watchdog #(.PRE_DIV(PRE), .ADDR_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .addr(addr),
        .wdata(wdata), .wr_en(wr_en), .rdata(rdata),
        .rst_req(rst_req), .early_irq(early_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; pclk_en = 1'b1;
        step(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        rd(4'h0, v); check("R1 ctrl", v, 32'h7F);
        rd(4'h4, v); check("R1 cfg", v, 32'h7F);
        rd(4'h8, v); check("R1 stat", v, 32'h0);
        check("R1 rst_req", rst_req, 0);
        check("R1 irq", early_irq, 0);

        // R13 reserved bits and unmapped offsets
        wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, v); check("R13 cfg", v, 32'h3FF);
        wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, v); check("R13 stat", v, 32'h0);
        wr(4'h0, 32'hFFFF_FF7F); rd(4'h0, v); check("R13 ctrl", v, 32'h7F);
        rd(4'hC, v); check("R13 unmapped", v, 32'h0);

        // R2 and R3: cycle-exact sweep over all time-base codes
        for (int t = 0; t < 4; t++) begin
            int per;
            per = PRE * (1 << t);
            do_reset();
            wr(4'h4, (t << 7) | 32'h7F);
            step(10);
            rd(4'h0, v); check("R2 inactive hold", v, 32'h7F);
            wr(4'h0, 32'hFF);
            for (int n = 1; n <= per * 3 + 2; n++) begin
                step(1);
                rd(4'h0, v);
                check($sformatf("R3 tb=%0d n=%0d", t, n), v, 32'h80 | (32'h7F - n / per));
                check("R2 no reset", rst_req, 0);
            end
        end

        // R5, R9, R12: warning and terminal step
        do_reset();
        wr(4'h4, 32'h7F);
        wr(4'h0, 32'hC5);
        for (int n = 1; n <= 30; n++) begin
            step(1);
            rd(4'h0, v); check("R5 count", v, 32'h80 | (32'h45 - n / PRE));
            check($sformatf("R5 pulse n=%0d", n), rst_req, (n == 24));
            rd(4'h8, v); check($sformatf("R9 flag n=%0d", n), v, (n >= 20));
            check("R12 irq disabled", early_irq, 0);
        end
        wr(4'h4, 32'h27F);
        check("R12 irq on enable", early_irq, 1);
        wr(4'h8, 32'h1);
        rd(4'h8, v); check("R10 write one keeps", v, 1);
        check("R12 irq held", early_irq, 1);
        wr(4'h8, 32'h0);
        rd(4'h8, v); check("R10 write zero clears", v, 0);
        check("R12 irq after clear", early_irq, 0);
        wr(4'h4, 32'h07F);
        rd(4'h4, v); check("R11 enable sticky", v, 32'h27F);

        // R6, R7, R4, R8: window and refresh
        do_reset();
        wr(4'h4, 32'h7E);
        wr(4'h0, 32'hFF);
        wr(4'h0, 32'hFF);
        check("R6 early refresh reset", rst_req, 1);
        rd(4'h0, v); check("R6 no load", v, 32'hFF);
        step(1);
        check("R5 pulse width", rst_req, 0);
        step(2);
        rd(4'h0, v); check("R2 first tick", v, 32'hFE);
        wr(4'h0, 32'h70);
        rd(4'h0, v); check("R7 reload and R4 stays active", v, 32'hF0);
        check("R7 no reset", rst_req, 0);
        wr(4'h0, 32'h30);
        check("R8 bit6 clear reset", rst_req, 1);
        rd(4'h0, v); check("R8 load", v, 32'hB0);

        // R14: enable gating
        do_reset();
        wr(4'h4, 32'h7F);
        pclk_en = 1'b0;
        wr(4'h0, 32'hFF);
        step(40);
        rd(4'h0, v); check("R14 stalled", v, 32'hFF);
        pclk_en = 1'b1;
        step(3);
        rd(4'h0, v); check("R14 before period", v, 32'hFF);
        step(1);
        rd(4'h0, v); check("R14 resumed", v, 32'hFE);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule